// File: doc/BRIEF.md
# Signed Integer Divider with Truncating and Flooring Rounding

This block divides one signed two's-complement integer by another over several clock cycles and returns both the quotient and the remainder. A one-bit mode input selects the rounding rule for each operation. In truncating mode the quotient rounds toward zero, and the remainder carries the sign of the dividend. These are the results of the signed `/` and `%` operators in SystemVerilog. In flooring mode the quotient rounds toward negative infinity, and the remainder carries the sign of the divisor. This is the modulo result that many programming languages return.

A caller presents the operands and the mode together with a one-cycle `start` while `busy` is low. The block captures all three on that edge. Inside, an iterative restoring divider works on the operand magnitudes and forms one quotient bit per clock. A sign-correction stage then applies the selected rounding rule and registers the results. When the results are ready, `done` pulses for one cycle. The quotient, the remainder and the zero-divisor flag then hold their values until the next operation completes.

Top module: `sdiv_round`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle on. `done` is high for exactly one cycle, after the WIDTH+1-th clock edge that follows the accepting edge. `busy` is low in that `done` cycle, so a `start` presented in the `done` cycle is accepted.
- R3: A `start` sampled while `busy` is high is ignored. The results reported at the next `done` come only from the operands and mode captured when the operation was accepted.
- R4: With `mode` = 0 (truncating), the quotient and remainder equal the signed `/` and `%` results truncated to WIDTH bits. For example, -10 by 3 gives -3 and -1, and 10 by -3 gives -3 and 1.
- R5: With `mode` = 1 (flooring), the quotient is the largest integer not above the true ratio. The remainder is dividend minus quotient times divisor, and it is either zero or has the sign of the divisor. For example, -10 by 3 gives -4 and 2, 10 by -3 gives -4 and -2, and -10 by -3 gives 3 and -1.
- R6: When the divisor divides the dividend exactly, both modes return the same quotient and a remainder of zero.
- R7: `div_by_zero` is 1 in the `done` cycle, and until the next completion, of an operation whose divisor was zero, and 0 otherwise. The quotient and remainder of such an operation carry no defined value.
- R8: The most negative dividend divided by -1 returns the most negative value as the quotient and zero as the remainder in both modes, and it completes with the normal latency.
- R9: `quotient`, `remainder` and `div_by_zero` change only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; honoured only while `busy` is low |
| mode | input | 1 | Rounding rule: 0 truncates toward zero, 1 floors toward minus infinity |
| dividend | input | WIDTH | Signed dividend, captured on acceptance |
| divisor | input | WIDTH | Signed divisor, captured on acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: the results have just been updated |
| quotient | output | WIDTH | Signed quotient of the last completed operation |
| remainder | output | WIDTH | Signed remainder of the last completed operation |
| div_by_zero | output | 1 | The last completed operation had a zero divisor |

## Verification
The two functions that can fall in the same cycle are the completion of one operation and the acceptance of the next. This happens when `start` is already high in the cycle where `done` pulses. The bench provokes it by issuing a chain of operations back to back with `start` held high. A behavioural model, run on every clock, predicts in which cycle each `done` appears and what `busy` and the held results should be. So a lost, doubled or late acceptance shows up as a mismatch in the cycle it happens. The bench also checks that a `start` raised in the middle of an operation, with different operands, leaves that operation's results unchanged.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_FLOOR = 1'b1
    } rnd_mode_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_WAIT = 1'b1
    } ctl_state_e;

    // Per-operation facts captured when a request is accepted
    typedef struct packed {
        logic      a_neg;
        logic      b_neg;
        logic      b_zero;
        rnd_mode_e mode;
    } op_flags_t;

    // Quotient negated when exactly one operand is negative
    function automatic logic quot_negate(op_flags_t f);
        return f.a_neg ^ f.b_neg;
    endfunction

    // Flooring adjustment: inexact result with differing operand signs
    function automatic logic floor_adjust(op_flags_t f, logic rem_nonzero);
        return (f.mode == RND_FLOOR) && quot_negate(f) && rem_nonzero;
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    input  logic             mode_i,
    output logic [WIDTH-1:0] num_mag_o,
    output logic [WIDTH-1:0] den_mag_o,
    output op_flags_t        flags_o
);

    localparam int MSB = WIDTH - 1;

    // Two's-complement magnitude; the most negative value maps to 2^(WIDTH-1)
    function automatic logic [WIDTH-1:0] magnitude(logic [WIDTH-1:0] v);
        return v[MSB] ? (~v + 1'b1) : v;
    endfunction

    always_comb begin
        num_mag_o      = magnitude(num_i);
        den_mag_o      = magnitude(den_i);
        flags_o.a_neg  = num_i[MSB];
        flags_o.b_neg  = den_i[MSB];
        flags_o.b_zero = (den_i == '0);
        flags_o.mode   = rnd_mode_e'(mode_i);
    end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] num_mag_i,
    input  logic [WIDTH-1:0] den_mag_i,
    output logic [WIDTH-1:0] quo_mag_o,
    output logic [WIDTH-1:0] rem_mag_o,
    output logic             fin_o
);

    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [WIDTH-1:0] rem_q, quo_q, den_q;
    logic [CW-1:0]    cnt_q;
    logic             run_q, fin_q;

    logic [WIDTH:0]   trial, diff;
    logic             fits;
    logic [WIDTH-1:0] rem_nxt;

    // One restoring step: shift in the next dividend bit, subtract if it fits
    always_comb begin
        trial   = {rem_q, quo_q[WIDTH-1]};
        diff    = trial - {1'b0, den_q};
        fits    = (trial >= {1'b0, den_q});
        rem_nxt = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                rem_q <= '0;
                quo_q <= num_mag_i;
                den_q <= den_mag_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nxt;
                quo_q <= {quo_q[WIDTH-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign quo_mag_o = quo_q;
    assign rem_mag_o = rem_q;
    assign fin_o     = fin_q;

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] quo_mag_i,
    input  logic [WIDTH-1:0] rem_mag_i,
    input  logic [WIDTH-1:0] den_i,
    input  op_flags_t        flags_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);

    logic [WIDTH-1:0] quo_t, rem_t;
    logic             adjust;

    always_comb begin
        // Truncating result: quotient sign from the operand signs, remainder from the dividend
        quo_t  = quot_negate(flags_i) ? (~quo_mag_i + 1'b1) : quo_mag_i;
        rem_t  = flags_i.a_neg ? (~rem_mag_i + 1'b1) : rem_mag_i;
        adjust = floor_adjust(flags_i, rem_mag_i != '0);
        if (adjust) begin
            quo_o = quo_t - 1'b1;
            rem_o = rem_t + den_i;
        end else begin
            quo_o = quo_t;
            rem_o = rem_t;
        end
    end

endmodule

// File: rtl/sdiv_round.sv
module sdiv_round
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_by_zero
);

    ctl_state_e       state_q;
    op_flags_t        flags_in, flags_q;
    logic [WIDTH-1:0] num_mag, den_mag, den_q;
    logic [WIDTH-1:0] quo_mag, rem_mag, quo_fix, rem_fix;
    logic             accept, fin;

    assign accept = start && (state_q == CTL_IDLE);

    sdiv_prep #(.WIDTH(WIDTH)) u_prep (
        .num_i     (dividend),
        .den_i     (divisor),
        .mode_i    (mode),
        .num_mag_o (num_mag),
        .den_mag_o (den_mag),
        .flags_o   (flags_in)
    );

    sdiv_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept),
        .num_mag_i (num_mag),
        .den_mag_i (den_mag),
        .quo_mag_o (quo_mag),
        .rem_mag_o (rem_mag),
        .fin_o     (fin)
    );

    sdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag_i (quo_mag),
        .rem_mag_i (rem_mag),
        .den_i     (den_q),
        .flags_i   (flags_q),
        .quo_o     (quo_fix),
        .rem_o     (rem_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CTL_IDLE;
            flags_q     <= '0;
            den_q       <= '0;
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                CTL_IDLE: begin
                    if (accept) begin
                        flags_q <= flags_in;
                        den_q   <= divisor;
                        state_q <= CTL_WAIT;
                    end
                end
                CTL_WAIT: begin
                    if (fin) begin
                        quotient    <= quo_fix;
                        remainder   <= rem_fix;
                        div_by_zero <= flags_q.b_zero;
                        done        <= 1'b1;
                        state_q     <= CTL_IDLE;
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign busy = (state_q == CTL_WAIT);

endmodule

// File: rtl/sdiv_round_chk.sv
module sdiv_round_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             mode,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             div_by_zero
);

    logic cap_zero, cap_aneg, cap_bneg, cap_floor;
    int   lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_zero  <= 1'b0;
            cap_aneg  <= 1'b0;
            cap_bneg  <= 1'b0;
            cap_floor <= 1'b0;
            lat_q     <= 0;
        end else if (start && !busy) begin
            cap_zero  <= (divisor == '0);
            cap_aneg  <= dividend[WIDTH-1];
            cap_bneg  <= divisor[WIDTH-1];
            cap_floor <= mode;
            lat_q     <= 0;
        end else if (busy) begin
            lat_q <= lat_q + 1;
        end
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == WIDTH + 1));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (div_by_zero == cap_zero));

    // R4
    trunc_rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_floor && !cap_zero && remainder != '0) |-> (remainder[WIDTH-1] == cap_aneg));

    // R5
    floor_rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cap_floor && !cap_zero && remainder != '0) |-> (remainder[WIDTH-1] == cap_bneg));

    // R9
    hold_results_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind sdiv_round sdiv_round_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode        (mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/sim_sdiv_round.sv
`timescale 1ns/1ps
module sim_sdiv_round;

    localparam int W = 16;
    localparam longint MINV = -(64'sd1 <<< (W - 1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sdiv_round #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    // Behavioural model, advanced on every rising edge
    logic         m_busy = 1'b0, m_done = 1'b0, m_dbz = 1'b0;
    logic [W-1:0] m_q = '0, m_r = '0;
    logic         p_dbz;
    logic [W-1:0] p_q, p_r;
    string        p_tag, m_tag = "R1";
    string        ovr_tag = "";
    int           m_cnt = 0;

    task automatic ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic md,
                           output logic [W-1:0] q, output logic [W-1:0] r, output string tag);
        longint sa, sb, lq, lr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (sb == 0) begin
            q = '0; r = '0; tag = "R7";
            return;
        end
        lq = sa / sb;
        lr = sa % sb;
        if (md && lr != 0 && ((lr < 0) != (sb < 0))) begin
            lq = lq - 1;
            lr = lr + sb;
        end
        q = lq[W-1:0];
        r = lr[W-1:0];
        if (sa == MINV && sb == -1) tag = "R8";
        else if (lr == 0)           tag = "R6";
        else if (md)                tag = "R5";
        else                        tag = "R4";
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
            m_q = '0; m_r = '0; m_dbz = 1'b0; m_tag = "R1";
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1;
                    m_q = p_q; m_r = p_r; m_dbz = p_dbz; m_tag = p_tag;
                end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = W + 1;
                ref_div(dividend, divisor, mode, p_q, p_r, p_tag);
                p_dbz = (divisor == '0);
                if (ovr_tag != "") p_tag = ovr_tag;
            end
        end
    end

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                fails++;
                $display("FAIL R2: busy=%0b done=%0b expected busy=%0b done=%0b at cycle %0d",
                         busy, done, m_busy, m_done, cycles);
            end
            checks++;
            if (div_by_zero !== m_dbz) begin
                fails++;
                $display("FAIL R7: div_by_zero=%0b expected %0b", div_by_zero, m_dbz);
            end
            if (!m_dbz) begin
                checks++;
                if (quotient !== m_q || remainder !== m_r) begin
                    fails++;
                    $display("FAIL %s: q=%0d r=%0d expected q=%0d r=%0d", m_tag,
                             $signed(quotient), $signed(remainder), $signed(m_q), $signed(m_r));
                end
            end
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic md);
        while (busy) @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; mode = md;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || div_by_zero !== 1'b0 ||
            quotient !== '0 || remainder !== '0) begin
            fails++;
            $display("FAIL R1: busy=%0b done=%0b dbz=%0b q=%0h r=%0h expected all 0",
                     busy, done, div_by_zero, quotient, remainder);
        end
        rst = 1'b0;
        @(negedge clk);

        // R4 and R5: all four sign combinations in both modes
        for (int md = 0; md < 2; md++) begin
            issue(-16'sd10, 16'sd3, md[0]);
            issue(16'sd10, -16'sd3, md[0]);
            issue(-16'sd10, -16'sd3, md[0]);
            issue(16'sd10, 16'sd3, md[0]);
            // R6: exact divisions
            issue(-16'sd12, 16'sd4, md[0]);
            issue(16'sd21, -16'sd7, md[0]);
            issue(16'sd0, -16'sd5, md[0]);
            // R8: most negative by -1
            issue(16'h8000, 16'hFFFF, md[0]);
            issue(16'h8000, 16'sd3, md[0]);
            // R7: zero divisor
            issue(16'sd77, 16'sd0, md[0]);
            issue(16'h8000, 16'sd0, md[0]);
        end

        // R3: start raised mid-operation with other operands must be ignored
        ovr_tag = "R3";
        start = 1'b1; dividend = -16'sd100; divisor = 16'sd7; mode = 1'b1;
        @(negedge clk);
        ovr_tag = "";
        dividend = 16'sd5; divisor = 16'sd0; mode = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);

        // R2: back-to-back, start held high across the done cycle
        start = 1'b1;
        for (int k = 0; k < 6; k++) begin
            dividend = W'($urandom); divisor = W'($urandom % 40) - W'(20); mode = k[0];
            @(negedge clk);
            while (!done) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);

        // R4 and R5: random operands
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (n % 3 == 0) ? W'($urandom % 64) - W'(32) : W'($urandom);
            issue(a, b, n[0]);
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule